// File: doc/BRIEF.md
# Single-Entry Posted Write Buffer

This block sits between a cache level and the level below it. When the upper level has to push a write downward, the buffer stores the address and data in its one slot. It grants the upper level right away, so the processor can go on to its next access, and then carries out the lower-level write by itself. While that write is still in flight, the buffer holds off every other access that needs the lower level, read or write, until the lower level acknowledges it.

Reads go through unchanged once the slot is empty. Only one downstream transaction is ever outstanding, so responses come back in request order. A build-time parameter adds one cycle of posting latency: the write is captured in the cycle it is presented, and the grant follows one cycle later. A busy output lets the owning cache level stall its miss handling while a write drains.

Top module: `post_wbuf`

## Requirements
- R1: After reset, `dn_req`, `busy` and `up_rvalid` are low, and `up_ready` is high while no request is presented.
- R2: With `POST_EXTRA`=0, a write presented while the buffer is idle gets `up_ready` high in the same cycle. In the next cycle, `dn_req` and `dn_write` are high and `dn_addr`/`dn_wdata` carry the captured address and data.
- R3: With `POST_EXTRA`=1, a write presented while idle sees `up_ready` low in its first cycle and high in the second cycle, and `dn_req` rises in the cycle after that grant.
- R4: While `dn_req` is high and `dn_ack` is low, `dn_req`, `dn_write`, `dn_addr` and `dn_wdata` stay unchanged into the next cycle.
- R5: A write is granted only while the slot is empty. While a buffered write is draining, `up_ready` stays low for any new request.
- R6: A read never reaches the lower level (`dn_req` high with `dn_write` low) while `busy` is high. A read that follows a write therefore returns the value of that write.
- R7: A read is forwarded with its address unchanged. `up_rvalid` pulses for one cycle, the cycle after `dn_ack` of that read, with `up_rdata` equal to the `dn_rdata` given with the acknowledge.
- R8: `busy` is high from the cycle after a write is captured until the cycle after its `dn_ack`, and a read never raises it.
- R9: Buffered writes reach the lower level one at a time and in the order the upper level issued them, each with its own address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upper level presents a request, held until granted |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | ADDR_W | Request address |
| up_wdata | input | DATA_W | Write data |
| up_ready | output | 1 | Request granted in this cycle when `up_valid` is high |
| up_rvalid | output | 1 | One-cycle pulse carrying read data |
| up_rdata | output | DATA_W | Read data returned to the upper level |
| dn_req | output | 1 | Lower-level request, held until `dn_ack` |
| dn_write | output | 1 | Lower-level request kind: 1 = write |
| dn_addr | output | ADDR_W | Lower-level address |
| dn_wdata | output | DATA_W | Lower-level write data |
| dn_ack | input | 1 | One-cycle completion from the lower level |
| dn_rdata | input | DATA_W | Read data, valid with `dn_ack` for a read |
| busy | output | 1 | A buffered write is posting or draining |

## Verification
The assertions check on every cycle that downstream requests stay stable until they are acknowledged, that a granted write raises busy, and that busy drops only after an acknowledge. They also check that no read goes downstream while busy and that read data appears only after a read acknowledge. Only the bench scenarios can show the rest: the grant timing in both latency variants, that a read after a write sees the newly written value, and that the lower memory ends up with the same contents as a reference model after a long random mix with random lower-level latency.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_POST  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_READ  = 2'd3
    } wb_state_e;

    typedef struct packed {
        wb_state_e state;
        logic      rvalid;
    } wb_ctrl_t;
endpackage

// File: rtl/wbuf_slot.sv
module wbuf_slot #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (load) begin
            slot_d.addr = addr_in;
            slot_d.data = data_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign addr_out = slot_q.addr;
    assign data_out = slot_q.data;
endmodule

// File: rtl/wbuf_resp.sv
module wbuf_resp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [DATA_W-1:0] rdata_out
);
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = load ? rdata_in : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata_out = rdata_q;
endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
    import wbuf_pkg::*;
#(
    parameter bit POST_EXTRA = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_valid,
    input  logic up_write,
    input  logic dn_ack,
    output logic up_ready,
    output logic slot_load,
    output logic rsp_load,
    output logic up_rvalid,
    output logic dn_req,
    output logic dn_write,
    output logic busy
);
    wb_ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rvalid = 1'b0;
        up_ready     = 1'b0;
        slot_load    = 1'b0;
        rsp_load     = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                up_ready = !(up_valid && up_write && POST_EXTRA);
                if (up_valid) begin
                    slot_load = 1'b1;
                    if (!up_write)        ctl_d.state = ST_READ;
                    else if (POST_EXTRA)  ctl_d.state = ST_POST;
                    else                  ctl_d.state = ST_DRAIN;
                end
            end
            ST_POST: begin
                up_ready    = 1'b1;
                ctl_d.state = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (dn_ack) ctl_d.state = ST_IDLE;
            end
            ST_READ: begin
                if (dn_ack) begin
                    rsp_load     = 1'b1;
                    ctl_d.rvalid = 1'b1;
                    ctl_d.state  = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, rvalid: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign dn_req    = (ctl_q.state == ST_DRAIN) || (ctl_q.state == ST_READ);
    assign dn_write  = (ctl_q.state == ST_DRAIN);
    assign busy      = (ctl_q.state == ST_DRAIN) || (ctl_q.state == ST_POST);
    assign up_rvalid = ctl_q.rvalid;

    // R5: a granted write leaves the buffer occupied
    a_r5_grant_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_write && up_ready) |=> busy);

    // R8: the slot frees only through a lower-level acknowledge
    a_r8_busy_ends_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(dn_ack));

    // R6: no read reaches the lower level while a write is pending
    a_r6_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_write) |-> !busy);

    // R7: read data only follows a read acknowledge
    a_r7_rsp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        up_rvalid |-> $past(dn_req && !dn_write && dn_ack));
endmodule

// File: rtl/post_wbuf.sv
module post_wbuf #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter bit POST_EXTRA = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    input  logic              up_write,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_wdata,
    output logic              up_ready,
    output logic              up_rvalid,
    output logic [DATA_W-1:0] up_rdata,
    output logic              dn_req,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic              dn_ack,
    input  logic [DATA_W-1:0] dn_rdata,
    output logic              busy
);
    logic slot_load;
    logic rsp_load;

    wbuf_ctrl #(.POST_EXTRA(POST_EXTRA)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_valid  (up_valid),
        .up_write  (up_write),
        .dn_ack    (dn_ack),
        .up_ready  (up_ready),
        .slot_load (slot_load),
        .rsp_load  (rsp_load),
        .up_rvalid (up_rvalid),
        .dn_req    (dn_req),
        .dn_write  (dn_write),
        .busy      (busy)
    );

    wbuf_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (slot_load),
        .addr_in  (up_addr),
        .data_in  (up_wdata),
        .addr_out (dn_addr),
        .data_out (dn_wdata)
    );

    wbuf_resp #(.DATA_W(DATA_W)) i_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rsp_load),
        .rdata_in  (dn_rdata),
        .rdata_out (up_rdata)
    );

    // R4: an unacknowledged downstream request holds its contents
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack) |=> (dn_req && $stable(dn_write)
                                 && $stable(dn_addr) && $stable(dn_wdata)));
endmodule

// File: tb/test_post_wbuf.sv
module test_post_wbuf;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          up_valid = 1'b0, up_write = 1'b0;
    logic [AW-1:0] up_addr = '0;
    logic [DW-1:0] up_wdata = '0;
    logic          up_ready, up_rvalid, dn_req, dn_write, busy;
    logic [DW-1:0] up_rdata, dn_wdata;
    logic [AW-1:0] dn_addr;
    logic          dn_ack = 1'b0;
    logic [DW-1:0] dn_rdata = '0;

    post_wbuf #(.ADDR_W(AW), .DATA_W(DW), .POST_EXTRA(1'b0)) i_post_wbuf (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_write(up_write),
        .up_addr(up_addr), .up_wdata(up_wdata), .up_ready(up_ready),
        .up_rvalid(up_rvalid), .up_rdata(up_rdata), .dn_req(dn_req),
        .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_ack(dn_ack), .dn_rdata(dn_rdata), .busy(busy));

    // second build with the extra posting cycle
    logic          x_valid = 1'b0;
    logic [AW-1:0] x_addr = '0;
    logic [DW-1:0] x_wdata = '0;
    logic          x_ready, x_rvalid, x_dn_req, x_dn_write, x_busy;
    logic [DW-1:0] x_rdata, x_dn_wdata;
    logic [AW-1:0] x_dn_addr;
    logic          x_dn_ack = 1'b0;

    post_wbuf #(.ADDR_W(AW), .DATA_W(DW), .POST_EXTRA(1'b1)) i_post_wbuf_x1 (
        .clk(clk), .rst_n(rst_n), .up_valid(x_valid), .up_write(1'b1),
        .up_addr(x_addr), .up_wdata(x_wdata), .up_ready(x_ready),
        .up_rvalid(x_rvalid), .up_rdata(x_rdata), .dn_req(x_dn_req),
        .dn_write(x_dn_write), .dn_addr(x_dn_addr), .dn_wdata(x_dn_wdata),
        .dn_ack(x_dn_ack), .dn_rdata('0), .busy(x_busy));

    always @(posedge clk) x_dn_ack <= rst_n && x_dn_req && !x_dn_ack;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // reference and lower memory
    logic [DW-1:0] ref_mem [16];
    logic [DW-1:0] low_mem [16];
    bit            pend = 1'b0;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_data;
    int            lat = 0;
    int            cnt = 0;

    function automatic logic [DW-1:0] expect_read(input logic [AW-1:0] a);
        return ref_mem[a[3:0]];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            dn_ack <= 1'b0;
            cnt = 0;
        end else if (dn_ack) begin
            dn_ack <= 1'b0;
            cnt = 0;
        end else if (dn_req) begin
            if (cnt >= lat) begin
                dn_ack <= 1'b1;
                if (dn_write) begin
                    chk(pend && dn_addr == pend_addr, "R9 write order addr",
                        DW'(dn_addr), DW'(pend_addr));
                    chk(dn_wdata == pend_data, "R9 write data", dn_wdata, pend_data);
                    low_mem[dn_addr[3:0]] <= dn_wdata;
                    pend = 1'b0;
                end else begin
                    dn_rdata <= low_mem[dn_addr[3:0]];
                end
                lat = int'($urandom % 4);
            end else begin
                cnt++;
            end
        end
    end

    task automatic access(input bit w, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output int waits);
        logic [DW-1:0] exp;
        waits = 0;
        @(negedge clk);
        up_valid = 1'b1; up_write = w; up_addr = a; up_wdata = d;
        forever begin
            #(CLK_PERIOD/4);
            if (up_ready) break;
            chk(busy || (w == 1'b0 && dn_req), "R5 stall only while draining",
                DW'(busy), 1);
            @(negedge clk);
            waits++;
        end
        if (w) begin
            chk(!pend, "R5 grant with slot empty", DW'(pend), 0);
            pend = 1'b1; pend_addr = a; pend_data = d;
            ref_mem[a[3:0]] = d;
        end
        exp = expect_read(a);
        @(posedge clk);
        @(negedge clk);
        up_valid = 1'b0;
        if (!w) begin
            chk(!busy, "R8 read leaves busy low", DW'(busy), 0);
            while (!up_rvalid) @(negedge clk);
            chk(up_rdata == exp, "R6/R7 read data", up_rdata, exp);
            @(negedge clk);
            chk(!up_rvalid, "R7 rvalid single pulse", DW'(up_rvalid), 0);
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int w;
        int unsigned seed;
        seed = $urandom(32'd11);
        for (int i = 0; i < 16; i++) begin
            ref_mem[i] = 32'h1000 + DW'(i);
            low_mem[i] = 32'h1000 + DW'(i);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!dn_req && !busy && !up_rvalid, "R1 outputs low in reset",
            {dn_req, busy, up_rvalid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(up_ready && !dn_req && !busy, "R1 idle after reset",
            {up_ready, dn_req, busy}, 32'h4);

        // R2 directed: write on empty buffer
        @(negedge clk);
        up_valid = 1'b1; up_write = 1'b1; up_addr = 8'h03; up_wdata = 32'hCAFE0003;
        #(CLK_PERIOD/4);
        chk(up_ready, "R2 same-cycle grant", DW'(up_ready), 1);
        pend = 1'b1; pend_addr = 8'h03; pend_data = 32'hCAFE0003;
        ref_mem[3] = 32'hCAFE0003;
        @(negedge clk);
        up_valid = 1'b0;
        chk(dn_req && dn_write, "R2 downstream write next cycle",
            {dn_req, dn_write}, 3);
        chk(dn_addr == 8'h03 && dn_wdata == 32'hCAFE0003, "R2 captured contents",
            dn_wdata, 32'hCAFE0003);
        chk(busy, "R8 busy after capture", DW'(busy), 1);
        // R5: a read right behind the write is held off, R6 sees the new value
        access(1'b0, 8'h03, '0, w);
        chk(w >= 1, "R5 read stalled behind drain", w, 1);
        // R8: busy cleared after drain
        chk(!busy && !dn_req, "R8 idle after drain", {busy, dn_req}, 0);

        // back-to-back writes, second must wait
        access(1'b1, 8'h05, 32'h55, w);
        access(1'b1, 8'h06, 32'h66, w);
        chk(w >= 1, "R5 second write stalled", w, 1);
        access(1'b0, 8'h05, '0, w);
        access(1'b0, 8'h06, '0, w);
        access(1'b0, 8'h09, '0, w);

        // random mix
        for (int n = 0; n < 600; n++) begin
            bit wr;
            logic [AW-1:0] a;
            wr = $urandom % 2 == 0;
            a  = AW'($urandom % 16);
            access(wr, a, $urandom, w);
            if ($urandom % 4 == 0) repeat ($urandom % 6) @(negedge clk);
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 16; i++)
            chk(low_mem[i] == ref_mem[i], "R9 final memory image", low_mem[i], ref_mem[i]);

        // R3 extra posting cycle
        @(negedge clk);
        x_valid = 1'b1; x_addr = 8'h0A; x_wdata = 32'hBEEF000A;
        #(CLK_PERIOD/4);
        chk(!x_ready, "R3 no grant in first cycle", DW'(x_ready), 0);
        @(negedge clk);
        #(CLK_PERIOD/4);
        chk(x_ready && x_busy, "R3 grant in second cycle", {x_ready, x_busy}, 3);
        chk(!x_dn_req, "R3 no request during grant cycle", DW'(x_dn_req), 0);
        @(negedge clk);
        x_valid = 1'b0;
        chk(x_dn_req && x_dn_write && x_dn_addr == 8'h0A && x_dn_wdata == 32'hBEEF000A,
            "R3 drain after grant", x_dn_wdata, 32'hBEEF000A);
        repeat (3) @(negedge clk);
        chk(!x_busy && !x_dn_req, "R8 extra build idle after drain", {x_busy, x_dn_req}, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule